// File: doc/BRIEF.md
# SPI Master with Byte FIFOs

This block is a memory-mapped SPI master. A host reaches it over a simple register bus with a byte address. Bytes written to the data register go into a transmit FIFO. A shift engine sends them MSB first on MOSI while a software-owned chip select is held low. To receive, software writes a byte count. The engine then clocks out dummy bytes and stores each byte it samples from MISO in a receive FIFO, which the host drains by reading the same data register.

Control registers select:
- the clock polarity and phase;
- an internal loopback from MOSI to the receive path;
- the SCK divider;
- a level-held reset of both FIFOs.

Four status flags report whether each FIFO is empty or full. A matching set of enables ANDs each flag into one interrupt line. A write to a full transmit FIFO raises a sticky abort flag. While that flag is set, further data writes are refused. Writing 1 to the flag clears it.

The shift engine is a three-state machine:
- ENG_IDLE: ENG_IDLE → ENG_HALF1 on "start transmit" when a transmit byte is waiting, or on "start receive" when the count is nonzero and the receive FIFO has room. Either start needs the chip select to be asserted.
- ENG_HALF1: ENG_HALF1 → ENG_HALF2 on "sample", at the end of the first half-period.
- ENG_HALF2: ENG_HALF2 → ENG_HALF1 on "next bit", at the end of the second half-period with bits left. ENG_HALF2 → ENG_IDLE on "byte end", after bit 0.

Top module: `spi_fifo_master`

## Requirements
- R1: Register offsets are data 0x00, chip-select/status 0x08, mode 0x10, receive count 0x18 and interrupt 0x20. Bits 7..4 of 0x08 read transmit empty, transmit full, receive empty and receive full, so the value after reset is 0xA0.
- R2: Bytes are shifted MSB first. SCK rests at the polarity bit (0x10 bit 5) when no byte is in flight. With the phase bit (0x10 bit 4) clear, MISO is sampled on the first SCK edge of each bit. With it set, MISO is sampled on the second edge.
- R3: A data write while the transmit FIFO is full is dropped and sets the abort flag (0x20 bit 2). Data writes are dropped while the flag is set. Writing 1 to that bit clears it.
- R4: A nonzero value written to 0x18 makes the engine send one 0xFF byte per count and push each received byte into the receive FIFO. 0x18 reads back the bytes not yet started. Writing 0 to 0x18 clears the activate bit (0x08 bit 0).
- R5: A data read pops the receive FIFO. A data read while the FIFO is empty returns the last byte read.
- R6: While 0x10 bit 7 is set, both FIFOs are held empty.
- R7: With 0x10 bit 6 set, the receive path takes MOSI instead of MISO.
- R8: The interrupt output is the OR of the four flags, each ANDed with its enable at 0x20 bits 7..4, in the same bit order as the flags in 0x08.
- R9: The chip select output is low exactly when the activate bit (0x08 bit 0) is set and a release request (0x08 bit 1) is not in force. The keep bit (0x08 bit 2) overrides the release request. A byte starts only while the chip select is low, and the chip select stays low between back-to-back bytes.
- R10: Each SCK half-period lasts (div>>1)+1 system clocks, where div is 0x10 bits 2..0. A div of 7 therefore gives an SCK period of 8 clocks.
- R11: Each FIFO holds 32 bytes. After 32 data writes with no byte sent, the transmit full flag is set.
- R12: When the receive FIFO is full, the engine waits, and the pending count is kept until space frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive data at 0x00) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: 32-entry FIFOs, a 3-bit divider, a 6-bit address and no address shift. The 32-entry depth lets the bench reach the transmit full and abort boundary in 32 writes. It also lets a 40-byte receive count fill the receive FIFO, so the engine stall and the remaining count of 8 can be observed. The 3-bit divider lets the bench run half-periods of 1, 2 and 4 clocks across all four polarity and phase combinations. An SPI slave model checks each of these against the bit timing.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_HALF1 = 2'd1,
        ENG_HALF2 = 2'd2
    } eng_state_t;

    localparam int OFS_DATA  = 8'h00;
    localparam int OFS_CSCTL = 8'h08;
    localparam int OFS_MODE  = 8'h10;
    localparam int OFS_RXCNT = 8'h18;
    localparam int OFS_IRQ   = 8'h20;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp_q, rp_q;
    logic [AW:0]      fill;
    logic             do_push, do_pop;

    assign fill    = wp_q - rp_q;
    assign empty   = (fill == '0);
    assign full    = (fill == (AW+1)'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rp_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
        end
    end

    // R11: a push into a full FIFO leaves it full and is otherwise lost
    p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              loop_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              tx_avail_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              rx_pending_i,
    input  logic              rx_room_i,
    input  logic              miso_i,
    output logic              tx_pop_o,
    output logic              rx_take_o,
    output logic              rx_push_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              sck_o,
    output logic              mosi_o
);
    localparam int BIT_W = $clog2(BYTE_W);

    eng_state_t        state_q, state_d;
    logic [DIV_W-1:0]  tmr_q, half_len;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q, rsh_q;
    logic              is_rx_q;
    logic              tmr_done, last_bit, start_tx, start_rx, miso_in;

    assign half_len = (div_i >> 1) + DIV_W'(1);
    assign tmr_done = (tmr_q == half_len - DIV_W'(1));
    assign last_bit = (bit_q == BIT_W'(BYTE_W-1));
    assign start_tx = (state_q == ENG_IDLE) && cs_active_i && tx_avail_i;
    assign start_rx = (state_q == ENG_IDLE) && cs_active_i && !tx_avail_i
                      && rx_pending_i && rx_room_i;
    assign miso_in  = loop_i ? mosi_o : miso_i;
    assign mosi_o   = sh_q[BYTE_W-1];
    assign rx_byte_o = rsh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (start_tx || start_rx) state_d = ENG_HALF1;
            ENG_HALF1: if (tmr_done) state_d = ENG_HALF2;
            ENG_HALF2: if (tmr_done) state_d = last_bit ? ENG_IDLE : ENG_HALF1;
            default:   state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            rsh_q   <= '0;
            is_rx_q <= 1'b0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start_tx || start_rx) begin
                        sh_q    <= start_tx ? tx_byte_i : {BYTE_W{1'b1}};
                        is_rx_q <= start_rx;
                        bit_q   <= '0;
                        tmr_q   <= '0;
                    end
                end
                ENG_HALF1: begin
                    if (tmr_done) begin
                        tmr_q <= '0;
                        rsh_q <= {rsh_q[BYTE_W-2:0], miso_in};
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ENG_HALF2: begin
                    if (tmr_done) begin
                        tmr_q <= '0;
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                        bit_q <= bit_q + 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tx_pop_o  = start_tx;
        rx_take_o = start_rx;
        rx_push_o = 1'b0;
        sck_o     = cpol_i;
        unique case (state_q)
            ENG_HALF1: sck_o = cpol_i ^ cpha_i;
            ENG_HALF2: begin
                sck_o     = ~(cpol_i ^ cpha_i);
                rx_push_o = tmr_done && last_bit && is_rx_q;
            end
            default: ;
        endcase
    end

    // R2: MOSI only moves at the end of a second half-period
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_HALF1) |=> $stable(mosi_o));
    // R9: a byte never begins while chip select is released
    p_start_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_IDLE && state_d == ENG_HALF1) |-> cs_active_i);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int OFS_SHIFT  = 0,
    parameter int FIFO_DEPTH = 32,
    parameter int DIV_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    input  logic              spi_miso
);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA  >> OFS_SHIFT);
    localparam logic [ADDR_W-1:0] A_CSCTL = ADDR_W'(OFS_CSCTL >> OFS_SHIFT);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE  >> OFS_SHIFT);
    localparam logic [ADDR_W-1:0] A_RXCNT = ADDR_W'(OFS_RXCNT >> OFS_SHIFT);
    localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(OFS_IRQ   >> OFS_SHIFT);

    logic             act_q, rel_q, keep_q;
    logic             flush_q, loop_q, cpol_q, cpha_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       cnt_q, last_rx_q;
    logic [3:0]       ien_q;
    logic             abort_q;

    logic       tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0] tx_head, rx_head, rx_byte;
    logic       wr_data, rd_data, tx_push, tx_pop, rx_pop, rx_push, rx_take;
    logic       cs_active;
    logic [3:0] flags;

    assign wr_data   = bus_wr && (bus_addr == A_DATA);
    assign rd_data   = bus_rd && (bus_addr == A_DATA);
    assign tx_push   = wr_data && !tx_full && !abort_q;
    assign rx_pop    = rd_data && !rx_empty;
    assign cs_active = act_q && !(rel_q && !keep_q);
    assign spi_cs_n  = !cs_active;
    assign flags     = {tx_empty, tx_full, rx_empty, rx_full};
    assign irq       = |(flags & ien_q);

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_q),
        .push(tx_push), .wdata(bus_wdata), .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_q),
        .push(rx_push), .wdata(rx_byte), .pop(rx_pop), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    spim_engine #(.BYTE_W(8), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cs_active_i(cs_active),
        .cpol_i(cpol_q), .cpha_i(cpha_q), .loop_i(loop_q), .div_i(div_q),
        .tx_avail_i(!tx_empty), .tx_byte_i(tx_head),
        .rx_pending_i(cnt_q != 8'd0), .rx_room_i(!rx_full), .miso_i(spi_miso),
        .tx_pop_o(tx_pop), .rx_take_o(rx_take), .rx_push_o(rx_push),
        .rx_byte_o(rx_byte), .sck_o(spi_sck), .mosi_o(spi_mosi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0; rel_q <= 1'b0; keep_q <= 1'b0;
            flush_q <= 1'b0; loop_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
            div_q <= '0; cnt_q <= '0; ien_q <= '0; abort_q <= 1'b0;
            last_rx_q <= '0;
        end else begin
            if (rx_take) cnt_q <= cnt_q - 8'd1;
            if (rx_pop)  last_rx_q <= rx_head;
            if (wr_data && tx_full) abort_q <= 1'b1;
            if (bus_wr) begin
                if (bus_addr == A_CSCTL) begin
                    act_q  <= bus_wdata[0];
                    rel_q  <= bus_wdata[1];
                    keep_q <= bus_wdata[2];
                end
                if (bus_addr == A_MODE) begin
                    flush_q <= bus_wdata[7];
                    loop_q  <= bus_wdata[6];
                    cpol_q  <= bus_wdata[5];
                    cpha_q  <= bus_wdata[4];
                    div_q   <= bus_wdata[DIV_W-1:0];
                end
                if (bus_addr == A_RXCNT) begin
                    cnt_q <= bus_wdata;
                    if (bus_wdata == 8'd0) act_q <= 1'b0;
                end
                if (bus_addr == A_IRQ) begin
                    ien_q <= bus_wdata[7:4];
                    if (bus_wdata[2]) abort_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == A_DATA)       bus_rdata = rx_empty ? last_rx_q : rx_head;
        else if (bus_addr == A_CSCTL) bus_rdata = {flags, 1'b0, keep_q, rel_q, act_q};
        else if (bus_addr == A_MODE)  bus_rdata = {flush_q, loop_q, cpol_q, cpha_q,
                                                   (4)'(div_q)};
        else if (bus_addr == A_RXCNT) bus_rdata = cnt_q;
        else if (bus_addr == A_IRQ)   bus_rdata = {ien_q, 1'b0, abort_q, 2'b00};
    end

    // R12: the engine never delivers a byte into a full receive FIFO
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    // R9: transmit bytes leave only under an asserted chip select
    p_tx_pop_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (cs_active && !tx_empty));
    // R3: a data write into a full FIFO raises the abort flag
    p_abort_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full) |=> abort_q);
    // R4: a zero count write drops the activate bit
    p_zero_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RXCNT && bus_wdata == 8'd0) |=> !act_q);
endmodule

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/100ps
module tb_spi_fifo_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq, spi_sck, spi_mosi, spi_cs_n, spi_miso;

    always #2.5 clk = ~clk;

    spi_fifo_master dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] mosi_q[$];
    logic [7:0] resp_q[$];
    logic [7:0] rx_exp_q[$];
    logic [7:0] resp_cur = 8'hA5;
    logic [7:0] sbyte = '0, mon_exp;
    logic       cur_cpha = 1'b0, prev_sck = 1'b0;
    int sbit = 0, half_exp = 1, tmis = 0, tcnt = 0, idx = 0, sck_tog = 0;
    longint cyc = 0, last_t = 0;

    assign spi_miso = resp_cur[3'(7 - sbit)];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // slave model and monitor side of the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (spi_sck !== prev_sck) sck_tog++;
        if (spi_cs_n) begin
            if (tcnt % 16 != 0) chk(0, "R9 cs rose inside a byte", tcnt, 0);
            tcnt = 0;
            sbit = 0;
        end else if (spi_sck !== prev_sck) begin
            idx = tcnt % 16;
            if (idx != 0 && (cyc - last_t) != longint'(half_exp)) tmis++;
            last_t = cyc;
            if ((idx % 2) == (cur_cpha ? 1 : 0)) begin
                sbyte = {sbyte[6:0], spi_mosi};
                if (idx >= 14) begin
                    if (mosi_q.size() == 0) chk(0, "R2 unexpected byte", sbyte, 0);
                    else begin
                        mon_exp = mosi_q.pop_front();
                        chk(sbyte == mon_exp, "R2 mosi byte", sbyte, mon_exp);
                    end
                end
            end
            if (!cur_cpha && (idx % 2 == 1)) sbit = ((idx + 1) / 2) % 8;
            if (cur_cpha && (idx % 2 == 0)) sbit = idx / 2;
            if (idx == 15) begin
                if (resp_q.size() > 0) void'(resp_q.pop_front());
                resp_cur = (resp_q.size() > 0) ? resp_q[0] : 8'hA5;
            end
            tcnt++;
        end
        prev_sck = spi_sck;
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic push_resp(input logic [7:0] b);
        resp_q.push_back(b);
        resp_cur = resp_q[0];
    endtask

    task automatic set_mode(input bit cpol, input bit cpha, input int div);
        wr(6'h10, {2'b00, cpol, cpha, 1'b0, 3'(div)});
        cur_cpha = cpha;
        half_exp = (div >> 1) + 1;
    endtask

    task automatic flush();
        wr(6'h10, 8'h80);
        wr(6'h10, 8'h00);
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && mosi_q.size() != 0; i++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(mosi_q.size() == 0, "R2 all bytes seen", mosi_q.size(), 0);
    endtask

    task automatic rx_pop_chk(input string tag);
        logic [7:0] v, e;
        e = (rx_exp_q.size() > 0) ? rx_exp_q.pop_front() : 8'h00;
        rd(6'h00, v);
        chk(v == e, tag, v, e);
    endtask

    task automatic xfer(input bit cpol, input bit cpha, input int div,
                        input logic [7:0] b0, input logic [7:0] b1);
        wr(6'h08, 8'h00);
        set_mode(cpol, cpha, div);
        tmis = 0;
        wr(6'h08, 8'h01);
        mosi_q.push_back(b0);
        mosi_q.push_back(b1);
        wr(6'h00, b0);
        wr(6'h00, b1);
        drain();
        chk(spi_sck == cpol, "R2 sck idle level", spi_sck, cpol);
        chk(spi_cs_n == 1'b0, "R9 cs held between bytes", spi_cs_n, 0);
        chk(tmis == 0, "R10 half-period length", tmis, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd_chk(6'h08, 8'hA0, "R1 status after reset");
        rd_chk(6'h18, 8'h00, "R1 count after reset");
        chk(spi_cs_n == 1'b1, "R9 cs idle", spi_cs_n, 1);
        chk(irq == 1'b0, "R8 irq idle", irq, 0);

        // R11 / R3: fill, overflow, abort blocking, clear
        for (int i = 0; i < 32; i++) wr(6'h00, 8'(i));
        rd_chk(6'h08, 8'h60, "R11 tx full after 32");
        chk(sck_tog == 0, "R9 no clocks without cs", sck_tog, 0);
        wr(6'h00, 8'h99);
        rd_chk(6'h20, 8'h04, "R3 abort set");
        flush();
        rd_chk(6'h08, 8'hA0, "R6 flush empties");
        wr(6'h00, 8'h11);
        rd_chk(6'h08, 8'hA0, "R3 write dropped while abort");
        wr(6'h20, 8'h04);
        rd_chk(6'h20, 8'h00, "R3 abort cleared");
        wr(6'h00, 8'h22);
        rd_chk(6'h08, 8'h20, "R3 write accepted after clear");

        // R8 interrupt
        wr(6'h20, 8'h40);
        chk(irq == 1'b0, "R8 tx full enable, not full", irq, 0);
        wr(6'h20, 8'h80);
        chk(irq == 1'b0, "R8 tx empty enable, not empty", irq, 0);
        flush();
        chk(irq == 1'b1, "R8 tx empty raises irq", irq, 1);
        wr(6'h20, 8'h20);
        chk(irq == 1'b1, "R8 rx empty raises irq", irq, 1);
        wr(6'h20, 8'h00);
        chk(irq == 1'b0, "R8 all disabled", irq, 0);

        // R2 / R10 / R9 transmit in all modes
        xfer(1'b0, 1'b0, 7, 8'hA6, 8'h59);
        xfer(1'b1, 1'b0, 2, 8'h81, 8'h7E);
        xfer(1'b0, 1'b1, 1, 8'hC3, 8'h01);
        xfer(1'b1, 1'b1, 0, 8'h5A, 8'hF0);
        wr(6'h08, 8'h03);
        chk(spi_cs_n == 1'b1, "R9 release request", spi_cs_n, 1);
        wr(6'h08, 8'h07);
        chk(spi_cs_n == 1'b0, "R9 keep overrides release", spi_cs_n, 0);
        wr(6'h08, 8'h00);

        // R4 / R5 receive by count
        set_mode(1'b0, 1'b0, 0);
        flush();
        push_resp(8'h3C); push_resp(8'hC3); push_resp(8'h5A);
        for (int i = 0; i < 3; i++) mosi_q.push_back(8'hFF);
        rx_exp_q.push_back(8'h3C); rx_exp_q.push_back(8'hC3); rx_exp_q.push_back(8'h5A);
        wr(6'h08, 8'h01);
        wr(6'h18, 8'd3);
        drain();
        for (int i = 0; i < 3; i++) rx_pop_chk("R4 received byte");
        rd_chk(6'h18, 8'h00, "R4 count consumed");
        rd_chk(6'h00, 8'h5A, "R5 empty read repeats last");

        // R7 loopback
        wr(6'h08, 8'h00);
        wr(6'h10, 8'h40);
        push_resp(8'h3C);
        mosi_q.push_back(8'hFF);
        wr(6'h08, 8'h01);
        wr(6'h18, 8'd1);
        drain();
        rd_chk(6'h00, 8'hFF, "R7 loopback takes mosi");

        // R12 receive stall on full FIFO
        wr(6'h08, 8'h00);
        wr(6'h10, 8'h00);
        for (int i = 0; i < 40; i++) mosi_q.push_back(8'hFF);
        wr(6'h08, 8'h01);
        wr(6'h18, 8'd40);
        repeat (900) @(negedge clk);
        rd_chk(6'h08, 8'h91, "R12 rx full and waiting");
        rd_chk(6'h18, 8'd8, "R12 count kept");
        for (int i = 0; i < 32; i++) rd_chk(6'h00, 8'hA5, "R4 default response");
        drain();
        for (int i = 0; i < 8; i++) rd_chk(6'h00, 8'hA5, "R12 resumed bytes");
        rd_chk(6'h18, 8'h00, "R12 count done");

        // R9 / R4 no start under release, zero count stops
        wr(6'h08, 8'h03);
        wr(6'h18, 8'd5);
        repeat (40) @(negedge clk);
        rd_chk(6'h18, 8'd5, "R9 no byte while released");
        wr(6'h18, 8'd0);
        rd_chk(6'h08, 8'hA2, "R4 zero count clears activate");
        chk(spi_cs_n == 1'b1, "R4 cs high after stop", spi_cs_n, 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule